// File: doc/BRIEF.md
# Digitizer Bus Register Decoder

This block sits behind the bus-slave front end of a multi-channel digitizer card. Each bus request carries a 24-bit address, a 6-bit address modifier, a direction flag and a 16-bit write word. The block works out which operation the request names and carries it out. Five operations are decoded:

- writing the card-wide control word;
- writing the suppression threshold of one channel;
- a single read that pops one word from one channel's FIFO;
- a block-transfer read that pops one word from the merged FIFO stream;
- a read of the number of block-transfer words taken so far.

The capture logic receives the sample count, the per-channel thresholds and one-cycle reset pulses. The FIFOs receive pop strobes. The bus side gets an acknowledge pulse carrying the read word. A request that matches no operation is never acknowledged, so the bus side can time it out.

Bits 23:20 of the address must be zero and bits 19:16 must equal the card's module index. Bits 15:8 carry a channel number counted from 1. Single-cycle accesses use modifier 0x3D. Block transfers use 0x3B or 0x3F.

Top module: `digi_bus_decoder`

## Requirements
- R1: A request is accepted only when address bits 23:20 are zero and bits 19:16 equal MOD_ID. Any other request gives no acknowledge, no strobe and no state change.
- R2: An accepted request raises `bus_ack` for exactly one cycle, on the edge after the request. `bus_rdata` holds the read word in that same cycle and is zero for writes.
- R3: A write to offset 0x0000 with modifier 0x3D loads `sample_count` from write bits 8:0. `sample_count` changes on no other access and resets to SCNT_RST.
- R4: In the control write of R3, write bit 9 gives a one-cycle `fifo_reset_pulse` and clears the block-transfer count to zero.
- R5: In the control write of R3, write bit 10 gives a one-cycle `thr_reset_pulse` and zeroes every threshold in the same cycle.
- R6: A write with modifier 0x3D to offset n*0x100, for 1 ≤ n ≤ NUM_CH, loads write bits 9:0 into the threshold of channel n. That threshold sits at `thr_flat[(n-1)*THR_W +: THR_W]`. All thresholds reset to zero.
- R7: A read with modifier 0x3D at offset n*0x100, for 1 ≤ n ≤ NUM_CH, returns slice n-1 of `chan_data`. With the acknowledge it pulses only `chan_pop[n-1]`.
- R8: A read at offset 0x0100 with modifier 0x3B or 0x3F returns `merge_data`, pulses `merge_pop` with the acknowledge, and adds one to the block-transfer count. The count saturates at 2^CNT_W-1.
- R9: A read at offset 0x0101 with modifier 0x3B or 0x3F returns the block-transfer count as it stood before that request, zero-extended.
- R10: The block-transfer modifiers take priority at offsets 0x0100 and 0x0101. Such an access never pops channel 1, and a write with these modifiers is not acknowledged.
- R11: A request with any other modifier is not acknowledged, and neither is a request to an unmapped offset. Unmapped offsets include a read of offset 0x0000, a nonzero low byte other than the block-count location, and a channel number of 0 or above NUM_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One cycle per bus request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Request address |
| bus_am | input | 6 | Address modifier |
| bus_wdata | input | DATA_W | Write word |
| bus_ack | output | 1 | Acknowledge pulse for an accepted request |
| bus_rdata | output | DATA_W | Read word, valid with bus_ack |
| sample_count | output | SCNT_W | Samples per trigger for capture logic |
| fifo_reset_pulse | output | 1 | One-cycle FIFO reset |
| thr_reset_pulse | output | 1 | One-cycle threshold reset |
| thr_flat | output | NUM_CH*THR_W | Channel thresholds, channel 1 lowest |
| chan_pop | output | NUM_CH | Per-channel FIFO pop strobes |
| chan_data | input | NUM_CH*DATA_W | Head word of each channel FIFO |
| merge_pop | output | 1 | Pop strobe of the merged stream |
| merge_data | input | DATA_W | Head word of the merged stream |

## Verification
Random requests draw the address from the mapped offsets and the neighbouring unmapped ones. The module index is sometimes wrong and the modifier is sometimes outside the listed three. This separates the offset decode, the module select and the modifier check. Directed sequences cover several cases:

- the two accesses that share offset 0x0100, which show whether the block-transfer modifier wins over channel 1;
- a run of block reads past the count limit, which shows saturation;
- a FIFO reset between count reads;
- a threshold reset after every channel has been loaded, which shows the clear reaching all of them.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CTRL_WR,
    OP_THR_WR,
    OP_CH_RD,
    OP_BLK_RD,
    OP_CNT_RD
  } op_e;

  localparam logic [5:0]  AM_SINGLE   = 6'h3D;
  localparam logic [5:0]  AM_BLK_A    = 6'h3B;
  localparam logic [5:0]  AM_BLK_B    = 6'h3F;
  localparam logic [15:0] OFS_CTRL    = 16'h0000;
  localparam logic [15:0] OFS_BLK_DAT = 16'h0100;
  localparam logic [15:0] OFS_BLK_CNT = 16'h0101;
  localparam int          BIT_FIFO_RST = 9;
  localparam int          BIT_THR_RST  = 10;

  function automatic logic is_blk_am(input logic [5:0] am);
    return (am == AM_BLK_A) || (am == AM_BLK_B);
  endfunction

  function automatic logic is_listed_am(input logic [5:0] am);
    return is_blk_am(am) || (am == AM_SINGLE);
  endfunction

  function automatic logic chan_in_range(input logic [7:0] num, input int nch);
    return (num != 8'd0) && (int'(num) <= nch);
  endfunction

endpackage

// File: rtl/dbd_decode.sv
module dbd_decode
  import dbd_pkg::*;
#(
  parameter int         NUM_CH = 8,
  parameter logic [3:0] MOD_ID = 4'd2,
  parameter int         CH_W   = 3
) (
  input  logic             req,
  input  logic             we,
  input  logic [23:0]      addr,
  input  logic [5:0]       am,
  output op_e              op,
  output logic [CH_W-1:0]  ch_idx
);

  logic       mod_hit;
  logic       ch_ok;
  logic [7:0] ch_num;

  always_comb begin
    mod_hit = (addr[23:20] == 4'd0) && (addr[19:16] == MOD_ID);
    ch_num  = addr[15:8];
    ch_ok   = (addr[7:0] == 8'd0) && chan_in_range(ch_num, NUM_CH);
    ch_idx  = CH_W'(ch_num - 8'd1);
    op      = OP_NONE;
    if (req && mod_hit) begin
      if (is_blk_am(am)) begin
        if (!we && addr[15:0] == OFS_BLK_DAT)      op = OP_BLK_RD;
        else if (!we && addr[15:0] == OFS_BLK_CNT) op = OP_CNT_RD;
      end else if (am == AM_SINGLE) begin
        if (addr[15:0] == OFS_CTRL) op = we ? OP_CTRL_WR : OP_NONE;
        else if (ch_ok)             op = we ? OP_THR_WR : OP_CH_RD;
      end
    end
  end

endmodule

// File: rtl/dbd_thr_bank.sv
module dbd_thr_bank #(
  parameter int NUM_CH = 8,
  parameter int THR_W  = 10,
  parameter int CH_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_idx,
  input  logic [THR_W-1:0]        wr_val,
  output logic [NUM_CH*THR_W-1:0] thr_flat
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_thr
    logic [THR_W-1:0] thr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   thr_q <= '0;
      else if (clr)                                 thr_q <= '0;
      else if (wr_en && wr_idx == CH_W'(g))         thr_q <= wr_val;
    end
    assign thr_flat[g*THR_W +: THR_W] = thr_q;
  end

endmodule

// File: rtl/dbd_blk_count.sv
module dbd_blk_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= sat_inc(count);
  end

endmodule

// File: rtl/digi_bus_decoder.sv
module digi_bus_decoder
  import dbd_pkg::*;
#(
  parameter int         ADDR_W  = 24,
  parameter int         DATA_W  = 16,
  parameter int         NUM_CH  = 8,
  parameter int         THR_W   = 10,
  parameter int         SCNT_W  = 9,
  parameter int         CNT_W   = 16,
  parameter logic [3:0] MOD_ID  = 4'd2,
  parameter logic [8:0] SCNT_RST = 9'd300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [5:0]               bus_am,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic                     bus_ack,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [SCNT_W-1:0]        sample_count,
  output logic                     fifo_reset_pulse,
  output logic                     thr_reset_pulse,
  output logic [NUM_CH*THR_W-1:0]  thr_flat,
  output logic [NUM_CH-1:0]        chan_pop,
  input  logic [NUM_CH*DATA_W-1:0] chan_data,
  output logic                     merge_pop,
  input  logic [DATA_W-1:0]        merge_data
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  op_e             dec_op;
  logic [CH_W-1:0] dec_ch;
  logic [CNT_W-1:0] blk_cnt;

  // named events for the checker and for readability
  logic acc_any, acc_ctrl, acc_thr, acc_chrd, acc_blk, acc_cnt;
  logic fifo_rst_now, thr_rst_now;
  logic unused_wbits;

  dbd_decode #(.NUM_CH(NUM_CH), .MOD_ID(MOD_ID), .CH_W(CH_W)) u_decode (
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr[23:0]),
    .am     (bus_am),
    .op     (dec_op),
    .ch_idx (dec_ch)
  );

  assign acc_any      = (dec_op != OP_NONE);
  assign acc_ctrl     = (dec_op == OP_CTRL_WR);
  assign acc_thr      = (dec_op == OP_THR_WR);
  assign acc_chrd     = (dec_op == OP_CH_RD);
  assign acc_blk      = (dec_op == OP_BLK_RD);
  assign acc_cnt      = (dec_op == OP_CNT_RD);
  assign fifo_rst_now = acc_ctrl && bus_wdata[BIT_FIFO_RST];
  assign thr_rst_now  = acc_ctrl && bus_wdata[BIT_THR_RST];
  assign unused_wbits = ^bus_wdata[DATA_W-1:BIT_THR_RST+1];

  dbd_thr_bank #(.NUM_CH(NUM_CH), .THR_W(THR_W), .CH_W(CH_W)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (thr_rst_now),
    .wr_en    (acc_thr),
    .wr_idx   (dec_ch),
    .wr_val   (bus_wdata[THR_W-1:0]),
    .thr_flat (thr_flat)
  );

  dbd_blk_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_rst_now),
    .inc   (acc_blk),
    .count (blk_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack          <= 1'b0;
      bus_rdata        <= '0;
      sample_count     <= SCNT_RST[SCNT_W-1:0];
      fifo_reset_pulse <= 1'b0;
      thr_reset_pulse  <= 1'b0;
      chan_pop         <= '0;
      merge_pop        <= 1'b0;
    end else begin
      bus_ack          <= acc_any;
      fifo_reset_pulse <= fifo_rst_now;
      thr_reset_pulse  <= thr_rst_now;
      merge_pop        <= acc_blk;
      chan_pop         <= '0;
      if (acc_chrd) chan_pop[dec_ch] <= 1'b1;
      if (acc_ctrl) sample_count <= bus_wdata[SCNT_W-1:0];
      unique case (dec_op)
        OP_CH_RD:  bus_rdata <= chan_data[dec_ch*DATA_W +: DATA_W];
        OP_BLK_RD: bus_rdata <= merge_data;
        OP_CNT_RD: bus_rdata <= DATA_W'(blk_cnt);
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dbd_checker.sv
module dbd_checker
  import dbd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int THR_W  = 10,
  parameter int SCNT_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic [5:0]              bus_am,
  input logic                    bus_ack,
  input logic [NUM_CH-1:0]       chan_pop,
  input logic                    merge_pop,
  input logic                    fifo_reset_pulse,
  input logic                    thr_reset_pulse,
  input logic [NUM_CH*THR_W-1:0] thr_flat,
  input logic [SCNT_W-1:0]       sample_count
);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req)); // R2

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_pop, merge_pop})); // R7

  AST_POP_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_pop) || merge_pop) |-> bus_ack); // R8

  AST_MERGE_BLK_AM: assert property (@(posedge clk) disable iff (!rst_n)
    merge_pop |-> is_blk_am($past(bus_am))); // R10

  AST_THR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    thr_reset_pulse |-> (thr_flat == '0)); // R5

  AST_BAD_AM_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !is_listed_am(bus_am)) |=> !bus_ack); // R11

  AST_SCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we) |=> $stable(sample_count)); // R3

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_reset_pulse || thr_reset_pulse) |-> $past(bus_req && bus_we)); // R4

endmodule

bind digi_bus_decoder dbd_checker #(
  .NUM_CH (NUM_CH),
  .THR_W  (THR_W),
  .SCNT_W (SCNT_W)
) u_dbd_checker (.*);

// File: tb/digi_bus_decoder_bench.sv
`timescale 1ns/1ps
module digi_bus_decoder_bench;

  localparam int         NCH   = 4;
  localparam logic [3:0] MODID = 4'd3;
  localparam int         CW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [5:0]  bus_am = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack;
  logic [15:0] bus_rdata;
  logic [8:0]  sample_count;
  logic        fifo_reset_pulse, thr_reset_pulse;
  logic [NCH*10-1:0] thr_flat;
  logic [NCH-1:0]    chan_pop;
  logic [NCH*16-1:0] chan_data = '0;
  logic        merge_pop;
  logic [15:0] merge_data = '0;

  int checks = 0, errors = 0;
  int unsigned m_scnt;
  logic [9:0]  m_thr [NCH];
  int          m_bcnt;

  always #2.5 clk = ~clk;

  digi_bus_decoder #(.NUM_CH(NCH), .CNT_W(CW), .MOD_ID(MODID)) u_digi_bus_decoder (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_am(bus_am), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .sample_count(sample_count), .fifo_reset_pulse(fifo_reset_pulse),
    .thr_reset_pulse(thr_reset_pulse), .thr_flat(thr_flat), .chan_pop(chan_pop),
    .chan_data(chan_data), .merge_pop(merge_pop), .merge_data(merge_data));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 control write, 2 threshold write, 3 channel read, 4 block read, 5 count read
  function automatic int classify(input logic we, input logic [23:0] a,
                                  input logic [5:0] am, output int ch);
    ch = int'(a[15:8]) - 1;
    if (a[23:16] != {4'h0, MODID}) return 0;
    if ((am == 6'h3B || am == 6'h3F) && !we) begin
      if (a[15:0] == 16'h0100) return 4;
      if (a[15:0] == 16'h0101) return 5;
      return 0;
    end
    if (am != 6'h3D) return 0;
    if (a[15:0] == 16'h0000) return we ? 1 : 0;
    if (a[7:0] == 8'h00 && ch >= 0 && ch < NCH) return we ? 2 : 3;
    return 0;
  endfunction

  function automatic logic [NCH*10-1:0] exp_thr();
    logic [NCH*10-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*10 +: 10] = m_thr[k];
    return v;
  endfunction

  task automatic access(input logic we, input logic [23:0] a, input logic [5:0] am,
                        input logic [15:0] wd, input string tag);
    int op, ch;
    logic [15:0] erd;
    logic [NCH-1:0] epop;
    @(negedge clk);
    chan_data  = {$urandom, $urandom};
    merge_data = 16'($urandom);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_am = am; bus_wdata = wd;
    op   = classify(we, a, am, ch);
    erd  = 16'h0;
    epop = '0;
    case (op)
      3: begin erd = chan_data[ch*16 +: 16]; epop[ch] = 1'b1; end
      4: erd = merge_data;
      5: erd = 16'(m_bcnt);
      default: ;
    endcase
    @(negedge clk);
    bus_req = 1'b0;
    chk({tag, " R1/R11 ack"}, 64'(bus_ack), 64'(op != 0));
    if (op != 0) chk({tag, " R2 rdata"}, 64'(bus_rdata), 64'(erd));
    chk({tag, " R7/R10 chan_pop"}, 64'(chan_pop), 64'(epop));
    chk({tag, " R8 merge_pop"}, 64'(merge_pop), 64'(op == 4));
    chk({tag, " R4 fifo pulse"}, 64'(fifo_reset_pulse), 64'(op == 1 && wd[9]));
    chk({tag, " R5 thr pulse"}, 64'(thr_reset_pulse), 64'(op == 1 && wd[10]));
    case (op)
      1: begin
        m_scnt = wd[8:0];
        if (wd[9]) m_bcnt = 0;
        if (wd[10]) for (int k = 0; k < NCH; k++) m_thr[k] = '0;
      end
      2: m_thr[ch] = wd[9:0];
      4: if (m_bcnt < (1 << CW) - 1) m_bcnt++;
      default: ;
    endcase
    chk({tag, " R3 sample_count"}, 64'(sample_count), 64'(m_scnt));
    chk({tag, " R6 thresholds"}, 64'(thr_flat), 64'(exp_thr()));
  endtask

  function automatic logic [23:0] mk(input logic [15:0] ofs);
    return {4'h0, MODID, ofs};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ofs;
    logic [3:0]  mid;
    logic [5:0]  am;
    logic [15:0] wd;
    void'($urandom(32'd20240517));
    m_scnt = 300; m_bcnt = 0;
    for (int k = 0; k < NCH; k++) m_thr[k] = '0;
    repeat (3) @(negedge clk);
    // reset state (R2, R3, R6)
    chk("reset R2 ack", 64'(bus_ack), 64'd0);
    chk("reset R3 sample_count", 64'(sample_count), 64'd300);
    chk("reset R6 thresholds", 64'(thr_flat), 64'd0);
    rst_n = 1'b1;
    // directed: control and thresholds
    access(1'b1, mk(16'h0000), 6'h3D, 16'h01AB, "ctrl R3");
    for (int n = 1; n <= NCH; n++) access(1'b1, mk(16'(n) << 8), 6'h3D, 16'(n * 100 + 7), "thr R6");
    access(1'b1, mk(16'h0000), 6'h3D, 16'h0400, "thr clear R5");
    // channel reads, including channel 1 at the shared offset
    for (int n = 1; n <= NCH; n++) access(1'b0, mk(16'(n) << 8), 6'h3D, 16'h0, "chan rd R7");
    // priority at 0x0100 and block count saturation
    for (int i = 0; i < 20; i++) access(1'b0, mk(16'h0100), (i % 2) ? 6'h3F : 6'h3B, 16'h0, "blk rd R8 R10");
    access(1'b0, mk(16'h0101), 6'h3B, 16'h0, "cnt sat R9");
    access(1'b1, mk(16'h0100), 6'h3B, 16'h0055, "blk write R10");
    access(1'b1, mk(16'h0000), 6'h3D, 16'h0200, "fifo rst R4");
    access(1'b0, mk(16'h0101), 6'h3F, 16'h0, "cnt cleared R4");
    // unmapped and foreign accesses
    access(1'b1, {4'h0, MODID ^ 4'h1, 16'h0000}, 6'h3D, 16'h0003, "wrong module R1");
    access(1'b1, {4'h8, MODID, 16'h0100}, 6'h3D, 16'h0003, "upper bits R1");
    access(1'b0, mk(16'h0000), 6'h3D, 16'h0, "read ctrl R11");
    access(1'b1, mk(16'(NCH + 1) << 8), 6'h3D, 16'h0011, "chan over R11");
    access(1'b1, mk(16'h0101), 6'h3D, 16'h0011, "single at cnt R11");
    access(1'b1, mk(16'h0000), 6'h39, 16'h0011, "bad am R11");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 8)
        0: ofs = 16'h0000;
        1: ofs = 16'h0100;
        2: ofs = 16'h0101;
        3, 4, 5: ofs = {8'($urandom % (NCH + 2)), 8'h00};
        6: ofs = 16'($urandom);
        default: ofs = {8'($urandom % (NCH + 2)), 8'h01};
      endcase
      mid = ($urandom % 8 == 0) ? 4'($urandom) : MODID;
      case ($urandom % 6)
        0, 1: am = 6'h3D;
        2: am = 6'h3B;
        3: am = 6'h3F;
        default: am = 6'($urandom);
      endcase
      wd = 16'($urandom);
      wd[10] = ($urandom % 8 == 0);
      wd[9]  = ($urandom % 4 == 0);
      access(1'($urandom % 2), {(($urandom % 16 == 0) ? 4'h2 : 4'h0), mid, ofs}, am, wd, "random R1 R6 R7 R8 R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule